// File: doc/BRIEF.md
# Memory Test Traffic Generator

This block exercises a memory through a simple command port. After a start request it runs a set number of passes. In each pass it writes a run of words and then reads the same run back. Every read it issues leaves an expected word in a small queue. Each returned word is compared with the oldest queued expectation. A mismatch raises a sticky flag, bumps a saturating counter, and records the address and data of the first failure.

Two choices are latched at start. The data choice is the word's own address, a hammer pattern that flips every bit on each beat, or a pseudo-random word. The address choice is a linear walk that wraps inside a begin/end window, or pseudo-random addresses held inside that window by two bit masks. One mask clears the bits above the range and the other sets the fixed boundary bit. Both generators restart from their seeds at the start of every phase, so a read phase replays the address and data stream of the write phase before it.

Top module: `mtg_top`

## Requirements
- R1: During reset and right after it, `cmd_valid`, `busy`, `done` and `err_flag` are low and `err_count` is zero.
- R2: A `start` seen while idle latches `addr_mode`, `data_mode`, `burst_len` (nonzero) and `pass_count` (a value of 0 or 1 gives one pass). Each pass issues `burst_len` writes (`cmd_we`=1) followed by `burst_len` reads (`cmd_we`=0). The reads use the same address sequence as the writes. While `busy` is low, `cmd_valid` is low.
- R3: `data_mode` 0 (and 3) sends the command address as the data. Mode 1 sends all ones on beat 0 of a phase and inverts every bit on each following beat. Mode 2 sends the data LFSR state: it is seeded with `DATA_SEED` at each phase start and advances once per accepted command.
- R4: `addr_mode` 0 starts each phase at `BEGIN_ADDR`, adds 1 per accepted command, and goes from `END_ADDR` back to `BEGIN_ADDR`. `addr_mode` 1 sends `(s & ~HI_MASK) | LO_MASK`. Here `s` is an LFSR seeded with `ADDR_SEED` at each phase start and advanced per accepted command. Both LFSRs step as `s' = {s[30:0], s[31]^s[21]^s[1]^s[0]}`.
- R5: Every address on `cmd_addr` lies between `BEGIN_ADDR` and `END_ADDR` inclusive.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_we`, `cmd_addr` and `cmd_wdata` hold their values into the next cycle.
- R7: Read data returns in order with any latency of one cycle or more. At most `FIFO_DEPTH` reads are outstanding, and further read commands stall until one returns.
- R8: A returned word that differs from its expectation sets `err_flag`, which stays set. It increments `err_count`, which saturates at 2^`ERR_W`-1. On the first mismatch only, it captures the expected address into `err_addr` and the returned word into `err_data`. An accepted `start` clears all four.
- R9: After the last read of the last pass has returned, `done` is high for exactly one cycle and `busy` is already low in that cycle.
- R10: A `start` raised while a run is in progress is ignored: the command stream and the configuration of that run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (acted on only when idle) |
| addr_mode | input | 1 | 0 linear walk, 1 pseudo-random addresses |
| data_mode | input | 2 | 0 address, 1 hammer, 2 pseudo-random data |
| burst_len | input | LEN_W | Words per phase |
| pass_count | input | PASS_W | Write/read passes per run |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_we | output | 1 | 1 write, 0 read |
| cmd_addr | output | ADDR_W | Word address |
| cmd_wdata | output | DATA_W | Write data |
| rd_valid | input | 1 | Read word returned |
| rd_data | input | DATA_W | Returned word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_flag | output | 1 | Sticky mismatch flag |
| err_count | output | ERR_W | Saturating mismatch count |
| err_addr | output | ADDR_W | Address of first mismatch |
| err_data | output | DATA_W | Returned word of first mismatch |

## Verification
Command fields are combinational from state, so they are due in the same cycle as `cmd_valid`. The bench samples them at the falling edge just before the accepting rising edge, after it has driven `cmd_ready`. Error outputs change on the rising edge that takes `rd_valid`, and `done` comes at least two edges after the last compare. The bench therefore checks the error outputs on the falling edge where `done` is first seen, and checks the end of the pulse one falling edge later. The bench's memory model returns reads in order after a random delay, and it predicts every mismatch from its own copy of memory, including addresses that a pseudo-random run visits twice.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } mtg_state_e;

  localparam logic [1:0] DM_ADDR   = 2'd0;
  localparam logic [1:0] DM_HAMMER = 2'd1;
  localparam logic [1:0] DM_PRBS   = 2'd2;

  localparam int unsigned LFSR_W = 32;

  // x^32 + x^22 + x^2 + x + 1, shifting toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/mtg_lfsr.sv
module mtg_lfsr
  import mtg_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);

  logic [LFSR_W-1:0] s_q, s_d;

  always_comb begin
    s_d = s_q;
    if (load)     s_d = SEED;
    else if (adv) s_d = lfsr_step(s_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         s_q <= SEED;
    else if (load | adv) s_q <= s_d;
  end

  assign state = s_q;

  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_q != '0);

endmodule

// File: rtl/mtg_addr_gen.sv
module mtg_addr_gen
  import mtg_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BEGIN_ADDR = 32'h0000_0400,
  parameter logic [ADDR_W-1:0] END_ADDR   = 32'h0000_07FF,
  parameter logic [ADDR_W-1:0] HI_MASK    = 32'hFFFF_F800,
  parameter logic [ADDR_W-1:0] LO_MASK    = 32'h0000_0400,
  parameter logic [LFSR_W-1:0] SEED       = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic              rand_mode,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] seq_q, seq_d;
  logic [LFSR_W-1:0] rnd;
  logic [ADDR_W-1:0] rnd_addr;

  mtg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (restart),
    .adv   (adv),
    .state (rnd)
  );

  generate
    if (ADDR_W <= LFSR_W) begin : g_narrow
      assign rnd_addr = (rnd[ADDR_W-1:0] & ~HI_MASK) | LO_MASK;
    end else begin : g_wide
      assign rnd_addr = ({{(ADDR_W-LFSR_W){1'b0}}, rnd} & ~HI_MASK) | LO_MASK;
    end
  endgenerate

  always_comb begin
    seq_d = seq_q;
    if (restart)                seq_d = BEGIN_ADDR;
    else if (adv)               seq_d = (seq_q == END_ADDR) ? BEGIN_ADDR : seq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seq_q <= BEGIN_ADDR;
    else if (restart | adv)  seq_q <= seq_d;
  end

  assign addr = rand_mode ? rnd_addr : seq_q;

  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= BEGIN_ADDR) && (addr <= END_ADDR));

  assert_seq_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rand_mode && adv && !restart && seq_q == END_ADDR) |=> (seq_q == BEGIN_ADDR));

endmodule

// File: rtl/mtg_data_gen.sv
module mtg_data_gen
  import mtg_pkg::*;
#(
  parameter int unsigned       ADDR_W = 32,
  parameter int unsigned       DATA_W = 32,
  parameter logic [LFSR_W-1:0] SEED   = 32'hACE1_2345
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  localparam int unsigned REP = (DATA_W + LFSR_W - 1) / LFSR_W;

  logic              ham_q, ham_d;
  logic [LFSR_W-1:0] rnd;
  logic [DATA_W-1:0] rnd_word;
  logic [DATA_W-1:0] addr_word;
  logic [REP*LFSR_W-1:0] rnd_rep;

  mtg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (restart),
    .adv   (adv),
    .state (rnd)
  );

  assign rnd_rep  = {REP{rnd}};
  assign rnd_word = rnd_rep[DATA_W-1:0];

  generate
    if (DATA_W >= ADDR_W) begin : g_addr_pad
      assign addr_word = {{(DATA_W-ADDR_W){1'b0}}, addr};
    end else begin : g_addr_cut
      assign addr_word = addr[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    ham_d = ham_q;
    if (restart)  ham_d = 1'b1;
    else if (adv) ham_d = ~ham_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ham_q <= 1'b1;
    else if (restart | adv) ham_q <= ham_d;
  end

  always_comb begin
    case (mode)
      DM_HAMMER: data = {DATA_W{ham_q}};
      DM_PRBS:   data = rnd_word;
      default:   data = addr_word;
    endcase
  end

  assert_hammer_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DM_HAMMER && adv && !restart) |=> (data == ~$past(data)));

endmodule

// File: rtl/mtg_exp_fifo.sv
module mtg_exp_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push | pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  assert_fifo_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  assert_fifo_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/mtg_top.sv
module mtg_top
  import mtg_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       LEN_W      = 16,
  parameter int unsigned       PASS_W     = 8,
  parameter int unsigned       ERR_W      = 16,
  parameter int unsigned       FIFO_DEPTH = 8,
  parameter logic [ADDR_W-1:0] BEGIN_ADDR = 32'h0000_0400,
  parameter logic [ADDR_W-1:0] END_ADDR   = 32'h0000_07FF,
  parameter logic [ADDR_W-1:0] HI_MASK    = 32'hFFFF_F800,
  parameter logic [ADDR_W-1:0] LO_MASK    = 32'h0000_0400,
  parameter logic [LFSR_W-1:0] ADDR_SEED  = 32'h0000_0001,
  parameter logic [LFSR_W-1:0] DATA_SEED  = 32'hACE1_2345
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              addr_mode,
  input  logic [1:0]        data_mode,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [PASS_W-1:0] pass_count,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err_flag,
  output logic [ERR_W-1:0]  err_count,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data
);

  localparam int unsigned EXP_W = ADDR_W + DATA_W;

  mtg_state_e        st_q, st_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic [LEN_W-1:0]  len_q;
  logic              amode_q;
  logic [1:0]        dmode_q;

  logic start_acc, fire, last_word, last_pass, restart;
  logic fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [EXP_W-1:0]  fifo_dout;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_data;
  logic              mismatch;

  logic              eflag_q, eflag_d;
  logic [ERR_W-1:0]  ecnt_q, ecnt_d;
  logic [ADDR_W-1:0] eaddr_q, eaddr_d;
  logic [DATA_W-1:0] edata_q, edata_d;

  // ---------------- control ----------------
  assign start_acc = start && (st_q == ST_IDLE);
  assign fire      = cmd_valid && cmd_ready;
  assign last_word = (left_q == LEN_W'(1));
  assign last_pass = (pass_q <= PASS_W'(1));

  assign restart = start_acc
                 || ((st_q == ST_WRITE) && fire && last_word)
                 || ((st_q == ST_DRAIN) && fifo_empty && !last_pass);

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    pass_d = pass_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_WRITE;
        left_d = burst_len;
        pass_d = pass_count;
      end
      ST_WRITE: if (fire) begin
        left_d = last_word ? len_q : left_q - 1'b1;
        if (last_word) st_d = ST_READ;
      end
      ST_READ: if (fire) begin
        left_d = left_q - 1'b1;
        if (last_word) st_d = ST_DRAIN;
      end
      ST_DRAIN: if (fifo_empty) begin
        if (last_pass) begin
          st_d = ST_DONE;
        end else begin
          st_d   = ST_WRITE;
          left_d = len_q;
          pass_d = pass_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      pass_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      pass_q <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      amode_q <= 1'b0;
      dmode_q <= DM_ADDR;
    end else if (start_acc) begin
      len_q   <= burst_len;
      amode_q <= addr_mode;
      dmode_q <= data_mode;
    end
  end

  // ---------------- generators ----------------
  mtg_addr_gen #(
    .ADDR_W     (ADDR_W),
    .BEGIN_ADDR (BEGIN_ADDR),
    .END_ADDR   (END_ADDR),
    .HI_MASK    (HI_MASK),
    .LO_MASK    (LO_MASK),
    .SEED       (ADDR_SEED)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .adv       (fire),
    .rand_mode (amode_q),
    .addr      (cmd_addr)
  );

  mtg_data_gen #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEED   (DATA_SEED)
  ) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (fire),
    .mode    (dmode_q),
    .addr    (cmd_addr),
    .data    (cmd_wdata)
  );

  assign cmd_valid = (st_q == ST_WRITE) || ((st_q == ST_READ) && !fifo_full);
  assign cmd_we    = (st_q == ST_WRITE);
  assign busy      = (st_q == ST_WRITE) || (st_q == ST_READ) || (st_q == ST_DRAIN);
  assign done      = (st_q == ST_DONE);

  // ---------------- expectation queue ----------------
  assign fifo_push = (st_q == ST_READ) && fire;
  assign fifo_pop  = rd_valid && !fifo_empty;

  mtg_exp_fifo #(
    .W     (EXP_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   ({cmd_addr, cmd_wdata}),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign exp_addr = fifo_dout[EXP_W-1:DATA_W];
  assign exp_data = fifo_dout[DATA_W-1:0];
  assign mismatch = fifo_pop && (rd_data != exp_data);

  // ---------------- error capture ----------------
  always_comb begin
    eflag_d = eflag_q;
    ecnt_d  = ecnt_q;
    eaddr_d = eaddr_q;
    edata_d = edata_q;
    if (start_acc) begin
      eflag_d = 1'b0;
      ecnt_d  = '0;
      eaddr_d = '0;
      edata_d = '0;
    end else if (mismatch) begin
      eflag_d = 1'b1;
      if (ecnt_q != {ERR_W{1'b1}}) ecnt_d = ecnt_q + 1'b1;
      if (!eflag_q) begin
        eaddr_d = exp_addr;
        edata_d = rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eflag_q <= 1'b0;
      ecnt_q  <= '0;
      eaddr_q <= '0;
      edata_q <= '0;
    end else if (start_acc | mismatch) begin
      eflag_q <= eflag_d;
      ecnt_q  <= ecnt_d;
      eaddr_q <= eaddr_d;
      edata_q <= edata_d;
    end
  end

  assign err_flag  = eflag_q;
  assign err_count = ecnt_q;
  assign err_addr  = eaddr_q;
  assign err_data  = edata_q;

  // ---------------- assertions ----------------
  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_we)
                                   && $stable(cmd_addr) && $stable(cmd_wdata)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> err_flag);

  assert_err_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == {ERR_W{1'b1}} && !start) |=> (err_count == {ERR_W{1'b1}}));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(amode_q) && $stable(dmode_q) && $stable(len_q)));

endmodule

// File: tb/mtg_top_test.sv
module mtg_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int ERR_W      = 4;
  localparam logic [31:0] B_ADDR = 32'h0000_0400;
  localparam logic [31:0] E_ADDR = 32'h0000_07FF;
  localparam logic [31:0] H_MASK = 32'hFFFF_F800;
  localparam logic [31:0] L_MASK = 32'h0000_0400;
  localparam logic [31:0] A_SEED = 32'h0000_0001;
  localparam logic [31:0] D_SEED = 32'hACE1_2345;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } cmd_t;

  logic        clk, rst_n, start, addr_mode;
  logic [1:0]  data_mode;
  logic [15:0] burst_len;
  logic [7:0]  pass_count;
  logic        cmd_valid, cmd_ready, cmd_we;
  logic [31:0] cmd_addr, cmd_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        busy, done, err_flag;
  logic [ERR_W-1:0] err_count;
  logic [31:0] err_addr, err_data;

  mtg_top #(
    .ERR_W (ERR_W), .FIFO_DEPTH (DEPTH),
    .BEGIN_ADDR (B_ADDR), .END_ADDR (E_ADDR),
    .HI_MASK (H_MASK), .LO_MASK (L_MASK),
    .ADDR_SEED (A_SEED), .DATA_SEED (D_SEED)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .addr_mode (addr_mode),
    .data_mode (data_mode), .burst_len (burst_len), .pass_count (pass_count),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_we (cmd_we),
    .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata), .rd_valid (rd_valid),
    .rd_data (rd_data), .busy (busy), .done (done), .err_flag (err_flag),
    .err_count (err_count), .err_addr (err_addr), .err_data (err_data)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // scoreboard state
  cmd_t        exp_q[$];
  logic [31:0] ret_d[$];
  int          ret_t[$];
  logic [31:0] mem [2048];
  int  cyc = 0, last_due = 0, outstanding = 0, max_out = 0, rd_idx = 0;
  int  exp_err = 0;
  logic [31:0] fe_addr, fe_data;
  int  corrupt_mode = 0, corrupt_idx = 0, lat_min = 1, lat_max = 3;
  bit  rdy_all = 1;
  bit  prev_stall = 0;
  cmd_t held;

  // driver: build the expected command stream of a run
  task automatic build_expected(input bit am, input logic [1:0] dm, input int len, input int np);
    logic [31:0] a_seq, a_l, d_l, a, d;
    for (int p = 0; p < (np < 1 ? 1 : np); p++) begin
      for (int ph = 0; ph < 2; ph++) begin
        a_seq = B_ADDR; a_l = A_SEED; d_l = D_SEED;
        for (int i = 0; i < len; i++) begin
          a = am ? ((a_l & ~H_MASK) | L_MASK) : a_seq;
          case (dm)
            2'd1:    d = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0;
            2'd2:    d = d_l;
            default: d = a;
          endcase
          exp_q.push_back('{we: (ph == 0), addr: a, data: d});
          a_seq = (a_seq == E_ADDR) ? B_ADDR : a_seq + 1;
          a_l = lfsr_next(a_l);
          d_l = lfsr_next(d_l);
        end
      end
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_valid  = 0;
      rd_data   = '0;
      cmd_ready = 0;
      prev_stall = 0;
    end else begin
      cyc++;
      if (prev_stall)
        chk(cmd_valid && cmd_we == held.we && cmd_addr == held.addr && cmd_wdata == held.data,
            "R6 hold while stalled", {cmd_valid, cmd_addr}, {1'b1, held.addr});
      if (ret_d.size() > 0 && ret_t[0] <= cyc) begin
        rd_valid = 1;
        rd_data  = ret_d.pop_front();
        void'(ret_t.pop_front());
        outstanding--;
      end else begin
        rd_valid = 0;
      end
      cmd_ready = rdy_all ? 1'b1 : ($urandom_range(3) != 0);
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected command", {cmd_we, cmd_addr}, 0);
        end else begin
          cmd_t e;
          e = exp_q.pop_front();
          chk(cmd_we == e.we, "R2 write/read order", cmd_we, e.we);
          chk(cmd_addr == e.addr, "R4 address sequence", cmd_addr, e.addr);
          chk(cmd_addr >= B_ADDR && cmd_addr <= E_ADDR, "R5 address window", cmd_addr, B_ADDR);
          chk(cmd_wdata == e.data, "R3 data pattern", cmd_wdata, e.data);
          if (cmd_we) begin
            mem[cmd_addr[10:0]] = cmd_wdata;
          end else begin
            logic [31:0] r;
            int due;
            r = mem[cmd_addr[10:0]];
            if (corrupt_mode == 2 || (corrupt_mode == 1 && rd_idx == corrupt_idx)) r = r ^ 32'h1;
            if (r != e.data) begin
              if (exp_err == 0) begin fe_addr = e.addr; fe_data = r; end
              exp_err++;
            end
            rd_idx++;
            due = cyc + $urandom_range(lat_max, lat_min);
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            ret_d.push_back(r);
            ret_t.push_back(due);
            outstanding++;
            if (outstanding > max_out) max_out = outstanding;
            chk(outstanding <= DEPTH, "R7 outstanding reads", outstanding, DEPTH);
          end
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      held = '{we: cmd_we, addr: cmd_addr, data: cmd_wdata};
    end
  end

  task automatic run(input bit am, input logic [1:0] dm, input int len, input int np,
                     input int cmode, input int kidx, input int lmin, input int lmax,
                     input bit rall, input bit poke);
    int sat;
    exp_err = 0; rd_idx = 0; max_out = 0;
    corrupt_mode = cmode; corrupt_idx = kidx;
    lat_min = lmin; lat_max = lmax; rdy_all = rall;
    build_expected(am, dm, len, np);
    @(negedge clk);
    addr_mode = am; data_mode = dm; burst_len = 16'(len); pass_count = 8'(np);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      addr_mode = ~am; data_mode = 2'd1; burst_len = 16'd3; pass_count = 8'd1;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    chk(exp_q.size() == 0, poke ? "R10 start ignored, stream intact" : "R2 all commands issued",
        exp_q.size(), 0);
    chk(ret_d.size() == 0, "R9 done after last return", ret_d.size(), 0);
    chk(!busy, "R9 busy low with done", busy, 0);
    sat = (exp_err > 15) ? 15 : exp_err;
    chk(err_flag == (exp_err > 0), "R8 error flag", err_flag, exp_err > 0);
    chk(err_count == ERR_W'(sat), "R8 error count", err_count, sat);
    if (exp_err > 0) begin
      chk(err_addr == fe_addr, "R8 first error address", err_addr, fe_addr);
      chk(err_data == fe_data, "R8 first error data", err_data, fe_data);
    end
    @(negedge clk);
    chk(!done, "R9 done is one cycle", done, 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    rst_n = 0; start = 0; addr_mode = 0; data_mode = 0; burst_len = 0; pass_count = 0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !busy && !done && !err_flag && err_count == 0, "R1 reset state",
        {cmd_valid, busy, done, err_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!cmd_valid && !busy && !done && !err_flag && err_count == 0, "R1 after reset",
        {cmd_valid, busy, done, err_flag}, 0);

    // R2 R3 R4: linear walk, address as data
    run(0, 2'd0, 16, 1, 0, 0, 1, 3, 1, 0);
    // R3: hammer over two passes with random ready
    run(0, 2'd1, 9, 2, 0, 0, 1, 4, 0, 0);
    // R3 R4 R8: random addresses and data, one corrupted read
    run(1, 2'd2, 40, 2, 1, 5, 1, 5, 0, 0);
    // R4 wrap and R7 stall: long run past the window end, long latency
    run(0, 2'd0, 1030, 1, 0, 0, 10, 14, 1, 0);
    chk(max_out == DEPTH, "R7 read stall at queue depth", max_out, DEPTH);
    // R8 saturation and R10 start while busy
    run(1, 2'd0, 20, 1, 2, 0, 1, 3, 0, 1);
    // R8: accepted start clears errors
    run(0, 2'd2, 12, 1, 0, 0, 2, 6, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule